// File: doc/BRIEF.md
# Floating-Point Vector Instruction Sequencer

This block runs a list of vector instructions that sits in a shared, word-addressed memory. It starts at address zero when `start` is pulsed. In its outer loop it reads four words per instruction and decodes them. In its inner loop it streams operand pairs out of memory into an external two-operand pipelined arithmetic core, and it writes each result back to memory. It continues until it fetches the stop word. It then raises `done` and stays quiet until the next start.

All traffic goes through one memory port. A read returns its data two cycles after the address is presented, and a write takes a single cycle. The two operand vectors are stored interleaved: left0, right0, left1, right1, and so on. Each pair gives one result. In steady state the inner loop reads one pair every four cycles and places the result writes in the free slots between the reads. The core is external to this block. It receives both operands with both ready flags in the same cycle and later returns a result with its own ready flag.

Top module: `fpvec_sequencer`

## Requirements
- R1: After reset `done` is low and `memEn` stays low until `start` is pulsed.
- R2: A start pulse makes the block read the first instruction at address 0. An instruction is four consecutive words: word 0 is the opcode, word 1 the input start, word 2 the output start, word 3 the element count. The next instruction is read at the current address plus 4.
- R3: For element i, the left operand is read at input start + 2i and the right operand at input start + 2i + 1. Both are handed to the core in the same cycle with `coreLeftRdy` and `coreRightRdy` both high. `coreOp` carries bits 7:0 of the opcode.
- R4: Result i is written to output start + i, in element order. An instruction makes exactly `count` writes.
- R5: A memory read is issued with `memEn` high and `memWe` low, and its data is taken from `memRdata` two cycles later. A write is issued with `memEn` and `memWe` both high.
- R6: In steady state, operand pairs are read once every four cycles. With an 8-cycle core, the first two results of a vector are written four cycles apart.
- R7: An instruction whose count is zero makes no operand reads and no writes, and the next instruction is fetched.
- R8: An opcode whose bits 23:0 are all ones stops execution, whatever its upper bits are. `done` goes high and no further memory access is made. An opcode that differs from this in any of bits 23:0 executes normally.
- R9: `done` stays high until the next start pulse. That pulse clears it and runs the program again from address 0.
- R10: A start pulse that arrives while an instruction list is running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at address 0 (only when not running) |
| memAddr | output | ADDR_W | Memory word address |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Write when high, read when low (with memEn) |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid two cycles after the read |
| coreOp | output | OP_W | Operation selector for the core |
| coreLeftRdy | output | 1 | Left operand valid |
| coreLeftData | output | DATA_W | Left operand |
| coreRightRdy | output | 1 | Right operand valid |
| coreRightData | output | DATA_W | Right operand |
| coreResRdy | input | 1 | Core result valid |
| coreResData | input | DATA_W | Core result |
| done | output | 1 | Halted; level held until next start |

## Verification
The assertions assume that the memory returns read data exactly two cycles after the read. They also assume that the core returns at most one result per operand pair, so the small result queue never overflows, and that output vectors do not overlap the input operands still to be read. The bench keeps within these assumptions. Its memory model has a fixed two-stage read pipeline, its core stub has a fixed eight-stage latency, and the program it loads places every output region apart from all inputs and instructions.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

  typedef struct packed {
    logic       rdInstr;
    logic [1:0] fetchIdx;
    logic       rdA;
    logic       rdB;
    logic       wrRes;
    logic       clrPc;
    logic       advPc;
    logic       clrElem;
  } ctrlStrobe_t;

  typedef struct packed {
    logic isHalt;
    logic cntZero;
    logic lastPair;
    logic allWritten;
    logic fifoEmpty;
  } dpStatus_t;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_DECODE, S_RUN, S_DRAIN, S_HALT
  } seqState_t;

  typedef enum logic [1:0] {
    K_INSTR = 2'd0, K_OPA = 2'd1, K_OPB = 2'd2
  } rdKind_t;

  localparam logic [23:0] STOP_CODE = 24'hFFFFFF;

endpackage

// File: rtl/vseq_fifo.sv
module vseq_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] headData,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] fill;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      fill  <= '0;
    end else begin
      if (push) begin
        store[wrPtr] <= pushData;
        wrPtr        <= bump(wrPtr);
      end
      if (pop) rdPtr <= bump(rdPtr);
      if (push && !pop) fill <= fill + 1'b1;
      else if (pop && !push) fill <= fill - 1'b1;
    end
  end

  assign headData = store[rdPtr];
  assign empty    = (fill == '0);

  AST_FIFO_NO_OVF: assert property (@(posedge clk) disable iff (!rstN)
    push |-> (fill < CW'(DEPTH)) || pop); // R4
  AST_FIFO_NO_UNDF: assert property (@(posedge clk) disable iff (!rstN)
    pop |-> fill != '0); // R4
endmodule

// File: rtl/vseq_datapath.sv
module vseq_datapath
  import vseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int OP_W       = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctrl,
  output dpStatus_t         status,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memEn,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [OP_W-1:0]   coreOp,
  output logic              coreLeftRdy,
  output logic [DATA_W-1:0] coreLeftData,
  output logic              coreRightRdy,
  output logic [DATA_W-1:0] coreRightData,
  input  logic              coreResRdy,
  input  logic [DATA_W-1:0] coreResData
);
  localparam int WORDS_PER_INSTR = 4;

  typedef struct packed {
    logic       valid;
    rdKind_t    kind;
    logic [1:0] idx;
  } rdTag_t;

  logic [ADDR_W-1:0] pc, inBase, outBase;
  logic [DATA_W-1:0] opReg, aHold;
  logic [CNT_W-1:0]  cntReg, elemIdx, wrIdx;
  rdTag_t            tag1, tag2, tagIssue;
  logic [DATA_W-1:0] fifoHead;
  logic              fifoEmpty;
  logic [ADDR_W-1:0] addrA;

  // read tag for the access issued this cycle
  always_comb begin
    tagIssue = '0;
    if (ctrl.rdInstr) begin
      tagIssue.valid = 1'b1;
      tagIssue.kind  = K_INSTR;
      tagIssue.idx   = ctrl.fetchIdx;
    end else if (ctrl.rdA) begin
      tagIssue.valid = 1'b1;
      tagIssue.kind  = K_OPA;
    end else if (ctrl.rdB) begin
      tagIssue.valid = 1'b1;
      tagIssue.kind  = K_OPB;
    end
  end

  // two-stage tag pipe matches the memory read latency
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tag1 <= '0;
      tag2 <= '0;
    end else begin
      tag1 <= tagIssue;
      tag2 <= tag1;
    end
  end

  // instruction field capture and operand hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opReg   <= '0;
      inBase  <= '0;
      outBase <= '0;
      cntReg  <= '0;
      aHold   <= '0;
    end else if (tag2.valid) begin
      unique case (tag2.kind)
        K_INSTR: begin
          unique case (tag2.idx)
            2'd0: opReg   <= memRdata;
            2'd1: inBase  <= memRdata[ADDR_W-1:0];
            2'd2: outBase <= memRdata[ADDR_W-1:0];
            default: cntReg <= memRdata[CNT_W-1:0];
          endcase
        end
        K_OPA:   aHold <= memRdata;
        default: ;
      endcase
    end
  end

  // program counter and element counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc      <= '0;
      elemIdx <= '0;
      wrIdx   <= '0;
    end else begin
      if (ctrl.clrPc) pc <= '0;
      else if (ctrl.advPc) pc <= pc + ADDR_W'(WORDS_PER_INSTR);
      if (ctrl.clrElem) begin
        elemIdx <= '0;
        wrIdx   <= '0;
      end else begin
        if (ctrl.rdB)   elemIdx <= elemIdx + 1'b1;
        if (ctrl.wrRes) wrIdx   <= wrIdx + 1'b1;
      end
    end
  end

  assign addrA = inBase + (ADDR_W'(elemIdx) << 1);

  // single memory port mux
  always_comb begin
    memAddr = '0;
    if (ctrl.rdInstr)    memAddr = pc + ADDR_W'(ctrl.fetchIdx);
    else if (ctrl.rdA)   memAddr = addrA;
    else if (ctrl.rdB)   memAddr = addrA + 1'b1;
    else if (ctrl.wrRes) memAddr = outBase + ADDR_W'(wrIdx);
  end
  assign memEn    = ctrl.rdInstr | ctrl.rdA | ctrl.rdB | ctrl.wrRes;
  assign memWe    = ctrl.wrRes;
  assign memWdata = fifoHead;

  // core operand hand-off: both sides together when the right word lands
  assign coreLeftRdy   = tag2.valid && (tag2.kind == K_OPB);
  assign coreRightRdy  = tag2.valid && (tag2.kind == K_OPB);
  assign coreLeftData  = aHold;
  assign coreRightData = memRdata;
  assign coreOp        = opReg[OP_W-1:0];

  vseq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) uResQ (
    .clk     (clk),
    .rstN    (rstN),
    .push    (coreResRdy),
    .pushData(coreResData),
    .pop     (ctrl.wrRes),
    .headData(fifoHead),
    .empty   (fifoEmpty)
  );

  always_comb begin
    status.isHalt     = (opReg[23:0] == STOP_CODE);
    status.cntZero    = (cntReg == '0);
    status.lastPair   = (elemIdx == cntReg - 1'b1);
    status.allWritten = (wrIdx == cntReg);
    status.fifoEmpty  = fifoEmpty;
  end

  AST_CORE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    coreLeftRdy |-> $past(ctrl.rdB, 2)); // R3
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wrRes |-> (wrIdx < cntReg)); // R4
  AST_PORT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctrl.rdInstr, ctrl.rdA, ctrl.rdB, ctrl.wrRes}) <= 1); // R5
endmodule

// File: rtl/vseq_control.sv
module vseq_control
  import vseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t ctrl,
  output logic        done
);
  seqState_t  state, nxt;
  logic [1:0] fetchCnt, phase;
  logic       waitCnt;

  always_comb begin
    ctrl = '0;
    nxt  = state;
    unique case (state)
      S_IDLE, S_HALT: begin
        if (start) begin
          ctrl.clrPc = 1'b1;
          nxt        = S_FETCH;
        end
      end
      S_FETCH: begin
        ctrl.rdInstr  = 1'b1;
        ctrl.fetchIdx = fetchCnt;
        if (fetchCnt == 2'd3) nxt = S_FWAIT;
      end
      S_FWAIT: begin
        if (waitCnt) nxt = S_DECODE;
      end
      S_DECODE: begin
        if (status.isHalt) begin
          nxt = S_HALT;
        end else if (status.cntZero) begin
          ctrl.advPc = 1'b1;
          nxt        = S_FETCH;
        end else begin
          ctrl.clrElem = 1'b1;
          nxt          = S_RUN;
        end
      end
      S_RUN: begin
        unique case (phase)
          2'd0: ctrl.rdA = 1'b1;
          2'd1: begin
            ctrl.rdB = 1'b1;
            if (status.lastPair) nxt = S_DRAIN;
          end
          default: ctrl.wrRes = !status.fifoEmpty;
        endcase
      end
      S_DRAIN: begin
        if (status.allWritten) begin
          ctrl.advPc = 1'b1;
          nxt        = S_FETCH;
        end else begin
          ctrl.wrRes = !status.fifoEmpty;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      fetchCnt <= '0;
      waitCnt  <= 1'b0;
      phase    <= '0;
    end else begin
      state    <= nxt;
      fetchCnt <= (state == S_FETCH) ? fetchCnt + 1'b1 : 2'd0;
      waitCnt  <= (state == S_FWAIT) ? !waitCnt : 1'b0;
      phase    <= (state == S_RUN) ? phase + 1'b1 : 2'd0;
    end
  end

  assign done = (state == S_HALT);

  AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DECODE && status.cntZero && !status.isHalt) |=> (state == S_FETCH)); // R7
  AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && start) |-> !ctrl.clrPc); // R10
endmodule

// File: rtl/fpvec_sequencer.sv
module fpvec_sequencer
  import vseq_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int OP_W       = 8,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memEn,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [OP_W-1:0]   coreOp,
  output logic              coreLeftRdy,
  output logic [DATA_W-1:0] coreLeftData,
  output logic              coreRightRdy,
  output logic [DATA_W-1:0] coreRightData,
  input  logic              coreResRdy,
  input  logic [DATA_W-1:0] coreResData,
  output logic              done
);
  ctrlStrobe_t ctrl;
  dpStatus_t   status;

  vseq_control uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .status(status),
    .ctrl  (ctrl),
    .done  (done)
  );

  vseq_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .OP_W(OP_W), .FIFO_DEPTH(FIFO_DEPTH)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .status       (status),
    .memAddr      (memAddr),
    .memEn        (memEn),
    .memWe        (memWe),
    .memWdata     (memWdata),
    .memRdata     (memRdata),
    .coreOp       (coreOp),
    .coreLeftRdy  (coreLeftRdy),
    .coreLeftData (coreLeftData),
    .coreRightRdy (coreRightRdy),
    .coreRightData(coreRightData),
    .coreResRdy   (coreResRdy),
    .coreResData  (coreResData)
  );

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memEn); // R8
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R9
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !done); // R9
endmodule

// File: tb/tb_fpvec_sequencer.sv
module tb_fpvec_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int MEM_WORDS = 4096;
  localparam int CORE_LAT = 8;
  localparam int WATCHDOG = 50000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic              memEn, memWe;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata;
  logic [7:0]        coreOp;
  logic              coreLeftRdy, coreRightRdy;
  logic [DATA_W-1:0] coreLeftData, coreRightData;
  logic              coreResRdy;
  logic [DATA_W-1:0] coreResData;
  logic              done;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpvec_sequencer dut (
    .clk(clk), .rstN(rstN), .start(start),
    .memAddr(memAddr), .memEn(memEn), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata),
    .coreOp(coreOp),
    .coreLeftRdy(coreLeftRdy), .coreLeftData(coreLeftData),
    .coreRightRdy(coreRightRdy), .coreRightData(coreRightData),
    .coreResRdy(coreResRdy), .coreResData(coreResData),
    .done(done)
  );

  // memory model: two-cycle read, one-cycle write
  logic [DATA_W-1:0] mem [MEM_WORDS];
  logic [11:0]       rdStageAddr;
  logic              rdStageVld;
  always_ff @(posedge clk) begin
    rdStageVld  <= memEn && !memWe;
    rdStageAddr <= memAddr[11:0];
    memRdata    <= rdStageVld ? mem[rdStageAddr] : 32'hDEAD_BEEF;
    if (memEn && memWe) mem[memAddr[11:0]] <= memWdata;
  end

  function automatic logic [31:0] coreFn(input logic [7:0] op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      8'h01:   return a + b;
      8'h02:   return a - b;
      8'h03:   return a * b;
      default: return a ^ b;
    endcase
  endfunction

  // core stub with fixed latency
  logic        pipeV [CORE_LAT];
  logic [31:0] pipeD [CORE_LAT];
  always_ff @(posedge clk) begin
    pipeV[0] <= coreLeftRdy && coreRightRdy;
    pipeD[0] <= coreFn(coreOp, coreLeftData, coreRightData);
    for (int s = 1; s < CORE_LAT; s++) begin
      pipeV[s] <= pipeV[s-1];
      pipeD[s] <= pipeD[s-1];
    end
  end
  assign coreResRdy  = pipeV[CORE_LAT-1] === 1'b1;
  assign coreResData = pipeD[CORE_LAT-1];

  // scoreboard
  typedef struct packed { logic [15:0] addr; logic [31:0] data; } wrItem_t;
  wrItem_t expQ [$];
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int wrCount = 0;
  int wrCyc [2];
  int coreIssues = 0;
  int coreSplit = 0;
  int zeroTouch = 0;
  int haltAccess = 0;
  logic trackGap = 1'b0;

  task automatic note(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic putInstr(input int at, input logic [31:0] op, input int inS, input int outS, input int n);
    mem[at]   = op;
    mem[at+1] = inS;
    mem[at+2] = outS;
    mem[at+3] = n;
    for (int i = 0; i < n; i++) begin
      mem[inS + 2*i]     = 32'h0001_0000 * (i + 1) + inS;
      mem[inS + 2*i + 1] = 32'd7 * i + 3 + inS;
    end
  endtask

  // driver: expected results pushed from the requirement model
  task automatic pushExpected(input logic [31:0] op, input int inS, input int outS, input int n);
    for (int i = 0; i < n; i++) begin
      wrItem_t it;
      it.addr = 16'(outS + i);
      it.data = coreFn(op[7:0], 32'h0001_0000 * (i + 1) + inS, 32'd7 * i + 3 + inS);
      expQ.push_back(it);
    end
  endtask

  task automatic pushProgram();
    pushExpected(32'h01, 100, 200, 8);
    pushExpected(32'h02, 300, 400, 3);
    pushExpected(32'h00FF_FFFE, 700, 800, 1);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      cyc++;
      if (done && memEn) haltAccess++;
      if (memEn && !memWe && memAddr >= 16'd500 && memAddr < 16'd520) zeroTouch++;
      if (coreLeftRdy || coreRightRdy) begin
        coreIssues++;
        if (!(coreLeftRdy && coreRightRdy)) coreSplit++;
      end
      if (memEn && memWe) begin
        if (trackGap && wrCount < 2) wrCyc[wrCount] = cyc;
        wrCount++;
        if (expQ.size() == 0) begin
          note(1'b0, "R4", "unexpected write addr", memAddr, 0);
        end else begin
          wrItem_t e;
          e = expQ.pop_front();
          note(memAddr == e.addr, "R4", "write address", memAddr, e.addr);
          note(memWdata == e.data, "R3", "result data", memWdata, e.data);
        end
      end
      if (cyc >= WATCHDOG) begin
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  initial begin
    for (int a = 0; a < MEM_WORDS; a++) mem[a] = 32'h5A5A_0000 + a;
    for (int s = 0; s < CORE_LAT; s++) begin
      pipeV[s] = 1'b0;
      pipeD[s] = '0;
    end
    rdStageVld = 1'b0;
    putInstr(0,  32'h01, 100, 200, 8);
    putInstr(4,  32'h02, 300, 400, 3);
    putInstr(8,  32'h03, 500, 600, 0);
    putInstr(12, 32'h00FF_FFFE, 700, 800, 1);
    mem[16] = 32'hA5FF_FFFF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    note(done == 1'b0, "R1", "done after reset", done, 0);
    note(memEn == 1'b0, "R1", "memEn after reset", memEn, 0);
    repeat (10) @(negedge clk);
    note(memEn == 1'b0 && wrCount == 0, "R1", "idle without start", memEn, 0);

    // first run
    pushProgram();
    trackGap = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    note(memEn && !memWe && memAddr == 0, "R2", "first fetch address", memAddr, 0);
    @(negedge clk);
    note(memEn && !memWe && memAddr == 1, "R2", "second fetch address", memAddr, 1);
    waitDone();
    trackGap = 1'b0;
    note(expQ.size() == 0, "R4", "results left unwritten", expQ.size(), 0);
    note(wrCount == 12, "R4", "total writes", wrCount, 12);
    note(wrCyc[1] - wrCyc[0] == 4, "R6", "first result spacing", wrCyc[1] - wrCyc[0], 4);
    note(mem[600] == 32'h5A5A_0000 + 600, "R7", "zero-count output untouched", mem[600], 32'h5A5A_0000 + 600);
    note(zeroTouch == 0, "R7", "zero-count operand reads", zeroTouch, 0);
    note(coreIssues == 12, "R3", "core hand-offs", coreIssues, 12);
    note(coreSplit == 0, "R3", "split ready flags", coreSplit, 0);
    note(mem[800] == coreFn(8'hFE, 32'h0001_0000 + 700, 32'd703), "R8", "near-stop opcode executed",
         mem[800], coreFn(8'hFE, 32'h0001_0000 + 700, 32'd703));
    repeat (20) @(negedge clk);
    note(done == 1'b1, "R9", "done held", done, 1);
    note(haltAccess == 0, "R8", "memory access after stop", haltAccess, 0);

    // second run, with a start pulse during execution
    pushProgram();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    note(done == 1'b0, "R9", "start clears done", done, 0);
    note(memEn && memAddr == 0, "R9", "restart from address 0", memAddr, 0);
    repeat (25) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    note(expQ.size() == 0, "R10", "results after mid-run start", expQ.size(), 0);
    note(wrCount == 24, "R10", "writes after mid-run start", wrCount, 24);
    note(coreIssues == 24, "R10", "core hand-offs second run", coreIssues, 24);
    repeat (5) @(negedge clk);
    note(haltAccess == 0, "R8", "memory access after second stop", haltAccess, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule